// File: doc/BRIEF.md
# Interrupt Class Priority Selector

This block holds the pending state of a CPU core's asynchronous interruption sources and decides, on each cycle where the core offers to accept one, which interruption class is delivered. The sources are a machine-check condition, a queued external request, a clock-comparator source and a CPU-timer source, and a set of I/O interruption subclasses (eight by default). Sources raise their pending flag with a one-cycle set pulse. When a source with a backing queue is granted, the requester tells the block whether that delivery empties the queue. The block clears the pending flag only in that case.

The current PSW is loaded into the block as a 64-bit word. From it the block takes the three class enables, the wait bit and the condition code. Two control-register words refine the choice. One gives a per-subclass enable for I/O. The other carries the machine-check enable. A grant is a one-cycle pulse with a one-hot class vector, the external interruption code and the chosen I/O subclass. The block also exposes the whole pending vector and a level request that is high while anything is pending.

Top module: `irq_class_sel`

## Requirements
- R1: After reset, no source is pending, `grant_valid` and `int_req` are low, `psw_cc` is 0 and `cpu_halted` is low.
- R2: No grant is made in a cycle where `exc_busy` is high (a program or supervisor-call exception already selected) or `take` is low, and in that cycle no pending flag is cleared.
- R3: Classes are tried in the order machine check, external, I/O. Each class is tried only while its PSW enable is set: PSW word bit 50 for machine check, bit 56 for external, bit 57 for I/O. A class with nothing eligible passes the choice to the next class.
- R4: Within the external class, the queued request wins over the clock comparator, and the clock comparator wins over the CPU timer. `ext_code` is 0x0000 for a queued request (its code travels with the queue), 0x1004 for the clock comparator and 0x1005 for the CPU timer.
- R5: I/O subclasses are scanned from 0 upward, and the first one that is pending and enabled is chosen. Subclass n is enabled by bit 31−n of `cr6_word`.
- R6: A machine check is eligible only while bit 28 of `cr14_word` is set. Otherwise it stays pending, and the lower classes are still tried.
- R7: `pend_vec` is {io[NUM_ISC−1:0], cpu-timer, clock-comparator, external, machine-check}, with machine check at bit 0. A granted queued source (machine check, external, I/O subclass) clears its flag only if its `*_last` input is high in the grant cycle. A granted timer source always clears its flag. A set pulse in the same cycle wins over a clear.
- R8: `int_req` is high exactly while `pend_vec` is non-zero.
- R9: A grant appears on the outputs in the cycle after the accepting cycle. It lasts one cycle per delivery, and `grant_class` is one-hot while `grant_valid` is high: bit 0 machine check, bit 1 external, bit 2 I/O. The class is zero otherwise.
- R10: After a PSW load whose word has the wait bit (bit 49) set and all three class enables clear, `cpu_halted` is high until the next load.
- R11: After a PSW load, `psw_cc` equals bits 45:44 of the loaded word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_mchk | input | 1 | Raise machine-check pending |
| set_ext | input | 1 | Raise queued external pending |
| set_tod | input | 1 | Raise clock-comparator pending |
| set_cpt | input | 1 | Raise CPU-timer pending |
| set_io | input | NUM_ISC | Raise I/O subclass pending, one bit per subclass |
| mchk_last | input | 1 | Machine-check queue empties on this grant |
| ext_last | input | 1 | External queue empties on this grant |
| io_last | input | NUM_ISC | Per-subclass queue empties on this grant |
| psw_load | input | 1 | Load a new PSW word |
| psw_word | input | 64 | PSW mask word being loaded |
| cr6_word | input | 32 | I/O subclass enables, subclass n at bit 31−n |
| cr14_word | input | 32 | Machine-check enable at bit 28 |
| exc_busy | input | 1 | Program or supervisor-call exception already selected |
| take | input | 1 | Core accepts an interruption this cycle |
| grant_valid | output | 1 | One-cycle grant pulse |
| grant_class | output | 3 | One-hot granted class |
| ext_code | output | 16 | External interruption code of the grant |
| io_isc | output | ISC_W | Granted I/O subclass |
| pend_vec | output | NUM_ISC+4 | Registered pending flags |
| int_req | output | 1 | Level request, high while anything is pending |
| psw_cc | output | 2 | Condition code of the current PSW |
| cpu_halted | output | 1 | Disabled wait state |

## Verification
The assertions assume that `take`, `exc_busy`, the set pulses, the `*_last` flags and the control words may change freely from cycle to cycle. They also assume that all inputs are stable around the rising edge. The stimulus drives every input on the falling edge and draws all of them at random, including PSW loads that remove enables while requests are pending. The `*_last` flags are also randomised outside grant cycles, where the block must ignore them. Directed phases first walk through every class, every external sub-source, gated subclasses, a withheld machine check and a disabled wait, so that the random phase is not the only source of coverage.

// File: rtl/intsel_pkg.sv
package intsel_pkg;

    // One-hot interruption class
    typedef enum logic [2:0] {
        CLS_NONE = 3'b000,
        CLS_MCHK = 3'b001,
        CLS_EXT  = 3'b010,
        CLS_IO   = 3'b100
    } cls_e;

    // External sub-source
    typedef enum logic [1:0] {
        EXT_QUEUED = 2'd0,
        EXT_CLKCMP = 2'd1,
        EXT_CPUTMR = 2'd2
    } ext_src_e;

    localparam logic [15:0] CODE_QUEUED = 16'h0000;
    localparam logic [15:0] CODE_CLKCMP = 16'h1004;
    localparam logic [15:0] CODE_CPUTMR = 16'h1005;

    // PSW word bit positions (bit 0 = least significant)
    localparam int PSW_IO_BIT   = 57;
    localparam int PSW_EXT_BIT  = 56;
    localparam int PSW_MCHK_BIT = 50;
    localparam int PSW_WAIT_BIT = 49;
    localparam int PSW_CC_LSB   = 44;

    // Control word bit positions
    localparam int CR14_MCHK_BIT = 28;
    localparam int CR6_ISC0_BIT  = 31;

endpackage

// File: rtl/intsel_psw.sv
module intsel_psw
    import intsel_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [63:0] word,
    output logic        en_io,
    output logic        en_ext,
    output logic        en_mchk,
    output logic [1:0]  cc,
    output logic        halted
);

    typedef struct packed {
        logic       en_io;
        logic       en_ext;
        logic       en_mchk;
        logic       wait_f;
        logic [1:0] cc;
    } psw_st_t;

    psw_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.en_io   = word[PSW_IO_BIT];
            st_d.en_ext  = word[PSW_EXT_BIT];
            st_d.en_mchk = word[PSW_MCHK_BIT];
            st_d.wait_f  = word[PSW_WAIT_BIT];
            st_d.cc      = word[PSW_CC_LSB +: 2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_io   = st_q.en_io;
    assign en_ext  = st_q.en_ext;
    assign en_mchk = st_q.en_mchk;
    assign cc      = st_q.cc;
    assign halted  = st_q.wait_f & ~(st_q.en_io | st_q.en_ext | st_q.en_mchk);

    // R10
    disabled_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && word[PSW_WAIT_BIT] && !word[PSW_IO_BIT] && !word[PSW_EXT_BIT]
         && !word[PSW_MCHK_BIT]) |=> halted);

    // R11
    cc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cc == $past(word[PSW_CC_LSB +: 2])));

endmodule

// File: rtl/intsel_io_pick.sv
module intsel_io_pick #(
    parameter int NUM_ISC = 8,
    localparam int ISC_W  = (NUM_ISC > 1) ? $clog2(NUM_ISC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_ISC-1:0] pend,
    input  logic [31:0]        cr6,
    output logic               found,
    output logic [ISC_W-1:0]   idx
);

    logic [NUM_ISC-1:0] elig;

    generate
        for (genvar g = 0; g < NUM_ISC; g++) begin : g_elig
            assign elig[g] = pend[g] & cr6[intsel_pkg::CR6_ISC0_BIT - g];
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int i = NUM_ISC - 1; i >= 0; i--) begin
            if (elig[i]) idx = ISC_W'(i);
        end
    end

    assign found = |elig;

    // R5
    lowest_isc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (pend[idx] && cr6[intsel_pkg::CR6_ISC0_BIT - int'(idx)]
                   && ((elig & ((NUM_ISC'(1) << idx) - NUM_ISC'(1))) == '0)));

endmodule

// File: rtl/intsel_arb.sv
module intsel_arb
    import intsel_pkg::*;
(
    input  logic        take,
    input  logic        exc_busy,
    input  logic        en_mchk,
    input  logic        en_ext,
    input  logic        en_io,
    input  logic        mchk_p,
    input  logic        mchk_ok,
    input  logic        ext_p,
    input  logic        tod_p,
    input  logic        cpt_p,
    input  logic        io_found,
    output cls_e        cls,
    output ext_src_e    src,
    output logic [15:0] code
);

    always_comb begin
        cls = CLS_NONE;
        src = EXT_QUEUED;
        if (take && !exc_busy) begin
            if (en_mchk && mchk_p && mchk_ok) begin
                cls = CLS_MCHK;
            end else if (en_ext && (ext_p || tod_p || cpt_p)) begin
                cls = CLS_EXT;
                if (ext_p)      src = EXT_QUEUED;
                else if (tod_p) src = EXT_CLKCMP;
                else            src = EXT_CPUTMR;
            end else if (en_io && io_found) begin
                cls = CLS_IO;
            end
        end
    end

    always_comb begin
        unique case (src)
            EXT_CLKCMP: code = CODE_CLKCMP;
            EXT_CPUTMR: code = CODE_CPUTMR;
            default:    code = CODE_QUEUED;
        endcase
    end

endmodule

// File: rtl/irq_class_sel.sv
module irq_class_sel
    import intsel_pkg::*;
#(
    parameter int NUM_ISC = 8,
    localparam int ISC_W  = (NUM_ISC > 1) ? $clog2(NUM_ISC) : 1,
    localparam int PEND_W = NUM_ISC + 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_mchk,
    input  logic               set_ext,
    input  logic               set_tod,
    input  logic               set_cpt,
    input  logic [NUM_ISC-1:0] set_io,
    input  logic               mchk_last,
    input  logic               ext_last,
    input  logic [NUM_ISC-1:0] io_last,
    input  logic               psw_load,
    input  logic [63:0]        psw_word,
    input  logic [31:0]        cr6_word,
    input  logic [31:0]        cr14_word,
    input  logic               exc_busy,
    input  logic               take,
    output logic               grant_valid,
    output logic [2:0]         grant_class,
    output logic [15:0]        ext_code,
    output logic [ISC_W-1:0]   io_isc,
    output logic [PEND_W-1:0]  pend_vec,
    output logic               int_req,
    output logic [1:0]         psw_cc,
    output logic               cpu_halted
);

    typedef struct packed {
        logic [NUM_ISC-1:0] io;
        logic               cpt;
        logic               tod;
        logic               ext;
        logic               mchk;
        logic               gvld;
        cls_e               gcls;
        logic [15:0]        gcode;
        logic [ISC_W-1:0]   gisc;
        logic               req;
    } sel_st_t;

    sel_st_t st_d, st_q;

    logic             en_io, en_ext, en_mchk;
    logic             io_found;
    logic [ISC_W-1:0] io_idx;
    cls_e             cls;
    ext_src_e         src;
    logic [15:0]      code;

    intsel_psw u_psw (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (psw_load),
        .word    (psw_word),
        .en_io   (en_io),
        .en_ext  (en_ext),
        .en_mchk (en_mchk),
        .cc      (psw_cc),
        .halted  (cpu_halted)
    );

    intsel_io_pick #(.NUM_ISC(NUM_ISC)) u_io_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (st_q.io),
        .cr6   (cr6_word),
        .found (io_found),
        .idx   (io_idx)
    );

    intsel_arb u_arb (
        .take     (take),
        .exc_busy (exc_busy),
        .en_mchk  (en_mchk),
        .en_ext   (en_ext),
        .en_io    (en_io),
        .mchk_p   (st_q.mchk),
        .mchk_ok  (cr14_word[CR14_MCHK_BIT]),
        .ext_p    (st_q.ext),
        .tod_p    (st_q.tod),
        .cpt_p    (st_q.cpt),
        .io_found (io_found),
        .cls      (cls),
        .src      (src),
        .code     (code)
    );

    always_comb begin
        st_d       = st_q;
        st_d.gvld  = (cls != CLS_NONE);
        st_d.gcls  = cls;
        st_d.gcode = (cls == CLS_EXT) ? code : '0;
        st_d.gisc  = (cls == CLS_IO) ? io_idx : '0;

        // consume the granted source
        unique case (cls)
            CLS_MCHK: if (mchk_last) st_d.mchk = 1'b0;
            CLS_EXT: begin
                unique case (src)
                    EXT_QUEUED: if (ext_last) st_d.ext = 1'b0;
                    EXT_CLKCMP: st_d.tod = 1'b0;
                    default:    st_d.cpt = 1'b0;
                endcase
            end
            CLS_IO:  if (io_last[io_idx]) st_d.io[io_idx] = 1'b0;
            default: ;
        endcase

        // new requests win over a clear
        st_d.mchk = st_d.mchk | set_mchk;
        st_d.ext  = st_d.ext  | set_ext;
        st_d.tod  = st_d.tod  | set_tod;
        st_d.cpt  = st_d.cpt  | set_cpt;
        st_d.io   = st_d.io   | set_io;
        st_d.req  = st_d.mchk | st_d.ext | st_d.tod | st_d.cpt | (|st_d.io);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign grant_valid = st_q.gvld;
    assign grant_class = st_q.gcls;
    assign ext_code    = st_q.gcode;
    assign io_isc      = st_q.gisc;
    assign pend_vec    = {st_q.io, st_q.cpt, st_q.tod, st_q.ext, st_q.mchk};
    assign int_req     = st_q.req;

    // R9
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid ? ($countones(grant_class) == 1) : (grant_class == 3'b000));

    // R2
    busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_busy || !take) |=> !grant_valid);

    // R6
    mchk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && grant_class == CLS_MCHK) |-> $past(cr14_word[CR14_MCHK_BIT]));

    // R8
    req_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_req == (pend_vec != '0));

    // R4
    ext_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && grant_class == CLS_EXT) |->
        (ext_code == CODE_QUEUED || ext_code == CODE_CLKCMP || ext_code == CODE_CPUTMR));

    // R3
    ext_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && grant_class == CLS_EXT) |-> $past(en_ext));

endmodule

// File: tb/irq_class_sel_test.sv
module irq_class_sel_test;

    localparam int NI = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        set_mchk = 0, set_ext = 0, set_tod = 0, set_cpt = 0;
    logic [NI-1:0] set_io = '0;
    logic        mchk_last = 0, ext_last = 0;
    logic [NI-1:0] io_last = '0;
    logic        psw_load = 0;
    logic [63:0] psw_word = '0;
    logic [31:0] cr6_word = '0, cr14_word = '0;
    logic        exc_busy = 0, take = 0;

    logic        grant_valid;
    logic [2:0]  grant_class;
    logic [15:0] ext_code;
    logic [2:0]  io_isc;
    logic [NI+3:0] pend_vec;
    logic        int_req;
    logic [1:0]  psw_cc;
    logic        cpu_halted;

    irq_class_sel #(.NUM_ISC(NI)) uut (
        .clk(clk), .rst_n(rst_n),
        .set_mchk(set_mchk), .set_ext(set_ext), .set_tod(set_tod), .set_cpt(set_cpt),
        .set_io(set_io), .mchk_last(mchk_last), .ext_last(ext_last), .io_last(io_last),
        .psw_load(psw_load), .psw_word(psw_word), .cr6_word(cr6_word), .cr14_word(cr14_word),
        .exc_busy(exc_busy), .take(take),
        .grant_valid(grant_valid), .grant_class(grant_class), .ext_code(ext_code),
        .io_isc(io_isc), .pend_vec(pend_vec), .int_req(int_req), .psw_cc(psw_cc),
        .cpu_halted(cpu_halted)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    bit m_mchk, m_ext, m_tod, m_cpt;
    bit [NI-1:0] m_io;
    bit m_gv;
    bit [2:0] m_gc;
    bit [15:0] m_code;
    bit [2:0] m_isc;
    bit m_eio, m_eext, m_emchk, m_wait;
    bit [1:0] m_cc;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_mchk = 0; m_ext = 0; m_tod = 0; m_cpt = 0; m_io = '0;
        m_gv = 0; m_gc = 0; m_code = 0; m_isc = 0;
        m_eio = 0; m_eext = 0; m_emchk = 0; m_wait = 0; m_cc = 0;
    endtask

    task automatic compare_all();
        chk("R9 grant_valid", grant_valid, m_gv);
        chk("R3 grant_class", grant_class, m_gc);
        chk("R4 ext_code", ext_code, m_code);
        chk("R5 io_isc", io_isc, m_isc);
        chk("R7 pend_vec", pend_vec, {m_io, m_cpt, m_tod, m_ext, m_mchk});
        chk("R8 int_req", int_req, (m_mchk | m_ext | m_tod | m_cpt | (|m_io)));
        chk("R11 psw_cc", psw_cc, m_cc);
        chk("R10 cpu_halted", cpu_halted, m_wait & ~(m_eio | m_eext | m_emchk));
    endtask

    // one clock: model computes from inputs driven since the last falling edge
    task automatic step();
        bit gv; bit [2:0] gc; bit [15:0] cd; bit [2:0] is;
        bit nm, ne, nt, nc; bit [NI-1:0] ni;
        nm = m_mchk; ne = m_ext; nt = m_tod; nc = m_cpt; ni = m_io;
        gv = 0; gc = 0; cd = 0; is = 0;
        if (take && !exc_busy) begin
            if (m_emchk && m_mchk && cr14_word[28]) begin
                gv = 1; gc = 3'b001;
                if (mchk_last) nm = 0;
            end else if (m_eext && (m_ext || m_tod || m_cpt)) begin
                gv = 1; gc = 3'b010;
                if (m_ext) begin cd = 16'h0000; if (ext_last) ne = 0; end
                else if (m_tod) begin cd = 16'h1004; nt = 0; end
                else begin cd = 16'h1005; nc = 0; end
            end else if (m_eio) begin
                for (int i = 0; i < NI; i++) begin
                    if (!gv && m_io[i] && cr6_word[31 - i]) begin
                        gv = 1; gc = 3'b100; is = 3'(i);
                        if (io_last[i]) ni[i] = 0;
                    end
                end
            end
        end
        nm |= set_mchk; ne |= set_ext; nt |= set_tod; nc |= set_cpt; ni |= set_io;
        @(negedge clk);
        if (!rst_n) begin
            model_reset();
        end else begin
            m_mchk = nm; m_ext = ne; m_tod = nt; m_cpt = nc; m_io = ni;
            m_gv = gv; m_gc = gc; m_code = cd; m_isc = is;
            if (psw_load) begin
                m_eio = psw_word[57]; m_eext = psw_word[56]; m_emchk = psw_word[50];
                m_wait = psw_word[49]; m_cc = psw_word[45:44];
            end
        end
        compare_all();
    endtask

    task automatic quiet();
        set_mchk = 0; set_ext = 0; set_tod = 0; set_cpt = 0; set_io = '0;
        psw_load = 0; exc_busy = 0; take = 0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R9 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        step();
        // R1 reset state
        chk("R1 reset grant", grant_valid, 0);
        chk("R1 reset pend", pend_vec, 0);
        chk("R1 reset req", int_req, 0);
        chk("R1 reset cc", psw_cc, 0);
        chk("R1 reset halted", cpu_halted, 0);

        // enable all classes, cc = 2
        psw_load = 1; psw_word = 64'h0;
        psw_word[57] = 1; psw_word[56] = 1; psw_word[50] = 1; psw_word[45:44] = 2'd2;
        step(); quiet();
        chk("R11 cc after load", psw_cc, 2);

        // raise everything
        set_mchk = 1; set_ext = 1; set_tod = 1; set_cpt = 1; set_io = 8'hA5;
        step(); quiet();
        chk("R8 req raised", int_req, 1);

        // busy: no grant, pending unchanged
        exc_busy = 1; take = 1; mchk_last = 1; ext_last = 1; io_last = '1;
        step();
        chk("R2 busy no grant", grant_valid, 0);
        chk("R2 busy pend kept", pend_vec, {8'hA5, 4'hF});

        // machine check withheld by cr14: external wins
        exc_busy = 0; cr14_word = 32'h0;
        cr6_word = 32'h0; cr6_word[31-5] = 1; cr6_word[31-7] = 1;
        step();
        chk("R6 mchk withheld class", grant_class, 3'b010);
        chk("R4 queued code", ext_code, 16'h0000);
        step();
        chk("R4 clock comparator code", ext_code, 16'h1004);
        step();
        chk("R4 cpu timer code", ext_code, 16'h1005);
        step();
        chk("R5 lowest enabled isc", io_isc, 5);
        chk("R3 io class", grant_class, 3'b100);
        step();
        chk("R5 next isc", io_isc, 7);
        step();
        chk("R5 gated isc no grant", grant_valid, 0);
        chk("R6 mchk still pending", pend_vec[0], 1);
        // enable machine check delivery
        cr14_word[28] = 1;
        step();
        chk("R3 mchk granted", grant_class, 3'b001);
        take = 0;
        step();
        chk("R9 single pulse", grant_valid, 0);

        // queued source kept when not last
        set_ext = 1; step(); set_ext = 0;
        take = 1; ext_last = 0;
        step();
        chk("R7 ext kept", pend_vec[1], 1);
        ext_last = 1;
        step();
        chk("R7 ext cleared", pend_vec[1], 0);
        take = 0; step();

        // disabled wait
        psw_load = 1; psw_word = 64'h0; psw_word[49] = 1; psw_word[45:44] = 2'd1;
        step(); psw_load = 0;
        chk("R10 halted", cpu_halted, 1);
        chk("R11 cc 1", psw_cc, 1);
        step();

        // random phase
        for (int n = 0; n < 4000; n++) begin
            set_mchk = ($urandom % 12) == 0;
            set_ext  = ($urandom % 8) == 0;
            set_tod  = ($urandom % 10) == 0;
            set_cpt  = ($urandom % 10) == 0;
            set_io   = 8'($urandom) & 8'($urandom) & 8'($urandom);
            mchk_last = $urandom % 2;
            ext_last  = $urandom % 2;
            io_last   = 8'($urandom);
            exc_busy  = ($urandom % 7) == 0;
            take      = ($urandom % 4) != 0;
            cr14_word = $urandom;
            if ($urandom % 5 == 0) cr6_word = $urandom;
            psw_load  = ($urandom % 25) == 0;
            psw_word  = {$urandom, $urandom};
            if ($urandom % 4 != 0) begin
                psw_word[57] = 1; psw_word[56] = 1; psw_word[50] = 1;
            end
            step();
        end
        quiet();
        step();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule